// File: doc/BRIEF.md
# Two-Sided Inter-Processor Mailbox

This block joins two processors, called side A and side B, through a shared set of message slots. Each side owns a sending bank and a receiving bank, and each bank has four channels. A channel holds one message of eight 32-bit words. To send, a side fills the words of a channel and then fires that channel. The other side then sees a status bit for the channel and, if it has enabled that channel, its interrupt goes high. It reads the eight words and writes a one to the status bit to acknowledge. That acknowledge also frees the channel for the sender.

Each side has its own single-cycle 32-bit register port and one level interrupt. The sending bank of a side sits at offsets 0x000 to 0x08F, and its receiving bank sits at the same offsets plus 0x100. Both banks use the same layout:
- fire (0x00): write-only, reads zero.
- enable (0x04).
- status (0x08).
- message words: channel n, word w at 0x10 + 32·n + 4·w.

Each direction and channel has its own control machine with three states:
- **CH_IDLE**: the slot is free and the sender may write words into it.
- **CH_PEND**: the message is outstanding and not every word has been read.
- **CH_DRAINED**: the message is outstanding and all eight words have been read.

The machine moves between them on these transitions:
- *fire*: CH_IDLE to CH_PEND. It clears the record of which words have been read.
- *drain*: CH_PEND to CH_DRAINED. It happens on the read that completes the set of eight distinct words.
- *release*: CH_DRAINED to CH_IDLE. It happens on the receiver's acknowledge.

In every other case the machine stays where it is.

Top module: `mbox_pair`

## Requirements
- R1: After the synchronous reset, every register on both sides reads zero and both interrupts are low.
- R2: The enable registers (0x004 sending, 0x104 receiving) hold bit n for channel n in bits 3:0 and read back the value written there. Bits 31:4 read as zero.
- R3: A write to word w of sending channel n (0x010 + 32·n + 4·w) while that channel is idle stores the word. The same value reads back at that offset on the sending side, and at 0x110 + 32·n + 4·w on the other side.
- R4: Writing bit n = 1 to the fire register (0x000) while sending enable bit n is set and the channel is idle makes the next cycle show bit n set in the sender's status (0x008) and in the peer's receive status (0x108).
- R5: A fire bit is ignored when the sending enable bit for that channel is clear, and also when the channel is already outstanding.
- R6: Writes to the words of an outstanding channel are dropped, so the peer keeps reading the message that was fired.
- R7: A side's interrupt is high exactly when some channel has both its receive enable bit and its receive status bit set.
- R8: A one written to bit n of the receive status (0x108) is ignored until all eight words of that channel have been read since it was fired. The words may be read in any order, and a repeated read counts once. Zero bits in the write have no effect.
- R9: An acknowledge on a drained channel clears the receive status bit and the sender's status bit in the same edge. The channel then accepts new words.
- R10: The following read as zero: the fire register, any offset outside the mapped registers, and any access whose address bits 1:0 are not zero. Writes to the sending status register and to unmapped offsets change nothing.
- R11: The two directions and the four channels work independently. Both sides can fire in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_sel | input | 1 | Side A access strobe |
| a_wr | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 10 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, same cycle, zero when not reading |
| a_irq | output | 1 | Side A receive interrupt |
| b_sel | input | 1 | Side B access strobe |
| b_wr | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 10 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, same cycle, zero when not reading |
| b_irq | output | 1 | Side B receive interrupt |

## Verification
The hardest state to reach from the ports is a channel that has been read on all but one word, with one word read twice, while acknowledges keep arriving. At that point the release must still be refused. The stimulus gets there by reading seven distinct words with a repeat, then writing acknowledges: before the last word, with zero bits, and with the wrong channel's bit. Only after the final word is read is the correct acknowledge sent. The bench also fires from both sides in the same cycle while one message is held in each direction, to show that the directions stay separate.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_PEND    = 2'd1,
        CH_DRAINED = 2'd2
    } ch_state_e;

    localparam int FIRE_WORD = 0;
    localparam int EN_WORD   = 1;
    localparam int STAT_WORD = 2;
    localparam int DATA_BASE = 'h10;

endpackage

// File: rtl/mbox_chan.sv
module mbox_chan
    import mbox_pkg::*;
#(
    parameter int DW    = 32,
    parameter int WORDS = 8,
    localparam int WIDX = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trig,
    input  logic            wr_en,
    input  logic [WIDX-1:0] snd_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic            rd_strobe,
    input  logic [WIDX-1:0] rcv_idx,
    input  logic            ack,
    output logic            busy,
    output logic [DW-1:0]   snd_rdata,
    output logic [DW-1:0]   rcv_rdata
);

    ch_state_e              state_q, state_d;
    logic [WORDS-1:0]       seen_q, seen_d;
    logic [WORDS-1:0][DW-1:0] slot_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_IDLE;
            seen_q  <= '0;
        end else begin
            state_q <= state_d;
            seen_q  <= seen_d;
        end
    end

    // message storage, writable only while free
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (wr_en && state_q == CH_IDLE) begin
            slot_q[snd_idx] <= wr_data;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        seen_d  = seen_q;
        unique case (state_q)
            CH_IDLE: begin
                if (trig) begin
                    state_d = CH_PEND;
                    seen_d  = '0;
                end
            end
            CH_PEND: begin
                if (rd_strobe) begin
                    seen_d[rcv_idx] = 1'b1;
                    if (&seen_d) state_d = CH_DRAINED;
                end
            end
            CH_DRAINED: begin
                if (ack) state_d = CH_IDLE;
            end
            default: begin
                state_d = CH_IDLE;
                seen_d  = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state_q != CH_IDLE);
        snd_rdata = slot_q[snd_idx];
        rcv_rdata = slot_q[rcv_idx];
    end

endmodule

// File: rtl/mbox_side_regs.sv
module mbox_side_regs
    import mbox_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int DW    = 32,
    parameter int AW    = 10,
    parameter int WORDS = 8,
    localparam int WIDX = $clog2(WORDS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sel,
    input  logic                   wr,
    input  logic [AW-1:0]          addr,
    input  logic [NCH-1:0]         wbits,
    output logic [DW-1:0]          rdata,
    output logic                   irq,
    input  logic [NCH-1:0]         tx_busy,
    input  logic [NCH-1:0]         rx_busy,
    input  logic [NCH-1:0][DW-1:0] tx_word,
    input  logic [NCH-1:0][DW-1:0] rx_word,
    output logic [NCH-1:0]         tx_trig,
    output logic [NCH-1:0]         tx_wr,
    output logic [NCH-1:0]         rx_rd,
    output logic [NCH-1:0]         rx_ack,
    output logic [WIDX-1:0]        widx,
    output logic [NCH-1:0]         tx_en,
    output logic [NCH-1:0]         rx_en
);

    localparam int CIDX     = $clog2(NCH);
    localparam int DATA_END = DATA_BASE + NCH * WORDS * 4;
    localparam int OFFW     = $clog2(DATA_END);
    localparam int WOFFW    = OFFW - 2;

    logic [NCH-1:0]   tx_en_q, rx_en_q;
    logic             ok, rx_bank, is_fire, is_en, is_stat, is_data;
    logic [WOFFW-1:0] woff, rel;
    logic [CIDX-1:0]  ch;
    logic [DW-1:0]    rd_mux;

    // decode
    always_comb begin
        ok      = (addr[1:0] == 2'b00) && (addr[AW-1:OFFW+1] == '0);
        rx_bank = addr[OFFW];
        woff    = addr[OFFW-1:2];
        rel     = woff - WOFFW'(DATA_BASE / 4);
        ch      = rel[CIDX+WIDX-1:WIDX];
        widx    = rel[WIDX-1:0];
        is_fire = ok && (woff == WOFFW'(FIRE_WORD));
        is_en   = ok && (woff == WOFFW'(EN_WORD));
        is_stat = ok && (woff == WOFFW'(STAT_WORD));
        is_data = ok && (woff >= WOFFW'(DATA_BASE / 4)) && (woff < WOFFW'(DATA_END / 4));
    end

    // enable registers
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_en_q <= '0;
            rx_en_q <= '0;
        end else if (sel && wr && is_en) begin
            if (rx_bank) rx_en_q <= wbits;
            else         tx_en_q <= wbits;
        end
    end

    // per-channel strobes
    for (genvar n = 0; n < NCH; n++) begin : g_strobe
        always_comb begin
            tx_trig[n] = sel && wr && !rx_bank && is_fire && wbits[n] && tx_en_q[n];
            tx_wr[n]   = sel && wr && !rx_bank && is_data && (ch == CIDX'(n));
            rx_rd[n]   = sel && !wr && rx_bank && is_data && (ch == CIDX'(n));
            rx_ack[n]  = sel && wr && rx_bank && is_stat && wbits[n];
        end
    end

    // read path
    always_comb begin
        rd_mux = '0;
        if (is_en)        rd_mux = {{(DW-NCH){1'b0}}, (rx_bank ? rx_en_q : tx_en_q)};
        else if (is_stat) rd_mux = {{(DW-NCH){1'b0}}, (rx_bank ? rx_busy : tx_busy)};
        else if (is_data) rd_mux = rx_bank ? rx_word[ch] : tx_word[ch];
        rdata = (sel && !wr) ? rd_mux : '0;
        irq   = |(rx_en_q & rx_busy);
        tx_en = tx_en_q;
        rx_en = rx_en_q;
    end

endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
    import mbox_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int DW    = 32,
    parameter int AW    = 10,
    parameter int WORDS = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_sel,
    input  logic          a_wr,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_irq,
    input  logic          b_sel,
    input  logic          b_wr,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq
);

    localparam int WIDX = $clog2(WORDS);

    logic [NCH-1:0]         ab_busy, ba_busy;
    logic [NCH-1:0][DW-1:0] ab_snd, ab_rcv, ba_snd, ba_rcv;
    logic [NCH-1:0]         a_trig, a_wrs, a_rd, a_ack, a_tx_en, a_rx_en;
    logic [NCH-1:0]         b_trig, b_wrs, b_rd, b_ack, b_tx_en, b_rx_en;
    logic [WIDX-1:0]        a_widx, b_widx;

    mbox_side_regs #(.NCH(NCH), .DW(DW), .AW(AW), .WORDS(WORDS)) u_side_a (
        .clk(clk), .rst(rst), .sel(a_sel), .wr(a_wr), .addr(a_addr),
        .wbits(a_wdata[NCH-1:0]), .rdata(a_rdata), .irq(a_irq),
        .tx_busy(ab_busy), .rx_busy(ba_busy), .tx_word(ab_snd), .rx_word(ba_rcv),
        .tx_trig(a_trig), .tx_wr(a_wrs), .rx_rd(a_rd), .rx_ack(a_ack),
        .widx(a_widx), .tx_en(a_tx_en), .rx_en(a_rx_en)
    );

    mbox_side_regs #(.NCH(NCH), .DW(DW), .AW(AW), .WORDS(WORDS)) u_side_b (
        .clk(clk), .rst(rst), .sel(b_sel), .wr(b_wr), .addr(b_addr),
        .wbits(b_wdata[NCH-1:0]), .rdata(b_rdata), .irq(b_irq),
        .tx_busy(ba_busy), .rx_busy(ab_busy), .tx_word(ba_snd), .rx_word(ab_rcv),
        .tx_trig(b_trig), .tx_wr(b_wrs), .rx_rd(b_rd), .rx_ack(b_ack),
        .widx(b_widx), .tx_en(b_tx_en), .rx_en(b_rx_en)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        mbox_chan #(.DW(DW), .WORDS(WORDS)) u_ab (
            .clk(clk), .rst(rst), .trig(a_trig[n]), .wr_en(a_wrs[n]),
            .snd_idx(a_widx), .wr_data(a_wdata), .rd_strobe(b_rd[n]),
            .rcv_idx(b_widx), .ack(b_ack[n]), .busy(ab_busy[n]),
            .snd_rdata(ab_snd[n]), .rcv_rdata(ab_rcv[n])
        );
        mbox_chan #(.DW(DW), .WORDS(WORDS)) u_ba (
            .clk(clk), .rst(rst), .trig(b_trig[n]), .wr_en(b_wrs[n]),
            .snd_idx(b_widx), .wr_data(b_wdata), .rd_strobe(a_rd[n]),
            .rcv_idx(a_widx), .ack(a_ack[n]), .busy(ba_busy[n]),
            .snd_rdata(ba_snd[n]), .rcv_rdata(ba_rcv[n])
        );
    end

endmodule

// File: rtl/mbox_pair_chk.sv
module mbox_pair_chk
    import mbox_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int AW    = 10,
    parameter int WORDS = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           a_sel,
    input logic           a_wr,
    input logic [AW-1:0]  a_addr,
    input logic [NCH-1:0] a_wbits,
    input logic           a_irq,
    input logic           b_sel,
    input logic           b_wr,
    input logic [AW-1:0]  b_addr,
    input logic [NCH-1:0] b_wbits,
    input logic           b_irq,
    input logic [NCH-1:0] ab_busy,
    input logic [NCH-1:0] ba_busy,
    input logic [NCH-1:0] a_tx_en,
    input logic [NCH-1:0] b_tx_en,
    input logic [NCH-1:0] a_rx_en,
    input logic [NCH-1:0] b_rx_en
);

    localparam int OFFW     = $clog2(DATA_BASE + NCH * WORDS * 4);
    localparam logic [AW-1:0] FIRE_ADDR = AW'(FIRE_WORD * 4);
    localparam logic [AW-1:0] ACK_ADDR  = AW'((1 << OFFW) + STAT_WORD * 4);

    logic a_fire_w, b_fire_w, a_ack_w, b_ack_w;
    assign a_fire_w = a_sel && a_wr && (a_addr == FIRE_ADDR);
    assign b_fire_w = b_sel && b_wr && (b_addr == FIRE_ADDR);
    assign a_ack_w  = a_sel && a_wr && (a_addr == ACK_ADDR);
    assign b_ack_w  = b_sel && b_wr && (b_addr == ACK_ADDR);

    // R7: an interrupt always has an enabled pending source behind it
    p_irq_source_r7_a: assert property (@(posedge clk) disable iff (rst)
        a_irq |-> |(a_rx_en & ba_busy));
    p_irq_source_r7_b: assert property (@(posedge clk) disable iff (rst)
        b_irq |-> |(b_rx_en & ab_busy));

    for (genvar n = 0; n < NCH; n++) begin : g_p
        // R4: an enabled fire on a free channel makes it outstanding
        p_fire_sets_r4_ab: assert property (@(posedge clk) disable iff (rst)
            (a_fire_w && a_wbits[n] && a_tx_en[n] && !ab_busy[n]) |=> ab_busy[n]);
        p_fire_sets_r4_ba: assert property (@(posedge clk) disable iff (rst)
            (b_fire_w && b_wbits[n] && b_tx_en[n] && !ba_busy[n]) |=> ba_busy[n]);
        // R5: without an enabled fire bit a free channel stays free
        p_no_fire_r5_ab: assert property (@(posedge clk) disable iff (rst)
            (!ab_busy[n] && !(a_fire_w && a_wbits[n] && a_tx_en[n])) |=> !ab_busy[n]);
        p_no_fire_r5_ba: assert property (@(posedge clk) disable iff (rst)
            (!ba_busy[n] && !(b_fire_w && b_wbits[n] && b_tx_en[n])) |=> !ba_busy[n]);
        // R8: an outstanding channel stays outstanding without an acknowledge
        p_busy_holds_r8_ab: assert property (@(posedge clk) disable iff (rst)
            (ab_busy[n] && !(b_ack_w && b_wbits[n])) |=> ab_busy[n]);
        p_busy_holds_r8_ba: assert property (@(posedge clk) disable iff (rst)
            (ba_busy[n] && !(a_ack_w && a_wbits[n])) |=> ba_busy[n]);
        // R9: a release is always caused by the peer's acknowledge
        p_release_ack_r9_ab: assert property (@(posedge clk) disable iff (rst)
            $fell(ab_busy[n]) |-> $past(b_ack_w && b_wbits[n]));
        p_release_ack_r9_ba: assert property (@(posedge clk) disable iff (rst)
            $fell(ba_busy[n]) |-> $past(a_ack_w && a_wbits[n]));
    end

endmodule

bind mbox_pair mbox_pair_chk #(.NCH(NCH), .AW(AW), .WORDS(WORDS)) u_chk (
    .clk(clk), .rst(rst),
    .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_wbits(a_wdata[NCH-1:0]), .a_irq(a_irq),
    .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_wbits(b_wdata[NCH-1:0]), .b_irq(b_irq),
    .ab_busy(ab_busy), .ba_busy(ba_busy),
    .a_tx_en(a_tx_en), .b_tx_en(b_tx_en), .a_rx_en(a_rx_en), .b_rx_en(b_rx_en)
);

// File: tb/mbox_pair_test.sv
`timescale 1ns/1ps
module mbox_pair_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_sel = 0, a_wr = 0, b_sel = 0, b_wr = 0;
    logic [9:0]  a_addr = '0, b_addr = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    always #10 clk = ~clk;

    mbox_pair uut (
        .clk(clk), .rst(rst),
        .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    // reference model: direction 0 is A->B, direction 1 is B->A
    logic [31:0] mem [2][4][8];
    logic [3:0]  busy [2];
    logic [7:0]  seen [2][4];
    logic [3:0]  txen [2];
    logic [3:0]  rxen [2];

    int    tests = 0, fails = 0;
    string req = "R1";

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        finish_up();
    end

    function automatic logic [31:0] exp_rd(int s, logic sel, logic wr, logic [9:0] a);
        int off, ch, w, d;
        if (!sel || wr || a[9] || a[1:0] != 0) return 0;
        off = {a[7:2], 2'b00};
        d   = a[8] ? 1 - s : s;
        if (off == 4)  return {28'd0, a[8] ? rxen[s] : txen[s]};
        if (off == 8)  return {28'd0, busy[d]};
        if (off >= 16 && off < 144) begin
            ch = (off - 16) / 32; w = ((off - 16) % 32) / 4;
            return mem[d][ch][w];
        end
        return 0;
    endfunction

    task automatic apply(int s, logic sel, logic wr, logic [9:0] a, logic [31:0] dat);
        int off, ch, w;
        if (!sel || a[9] || a[1:0] != 0) return;
        off = {a[7:2], 2'b00};
        ch = (off - 16) / 32; w = ((off - 16) % 32) / 4;
        if (wr) begin
            if (!a[8] && off == 0) begin
                for (int n = 0; n < 4; n++)
                    if (dat[n] && txen[s][n] && !busy[s][n]) begin
                        busy[s][n] = 1'b1; seen[s][n] = 8'h00;
                    end
            end else if (off == 4) begin
                if (a[8]) rxen[s] = dat[3:0]; else txen[s] = dat[3:0];
            end else if (a[8] && off == 8) begin
                for (int n = 0; n < 4; n++)
                    if (dat[n] && busy[1-s][n] && seen[1-s][n] == 8'hFF) busy[1-s][n] = 1'b0;
            end else if (!a[8] && off >= 16 && off < 144) begin
                if (!busy[s][ch]) mem[s][ch][w] = dat;
            end
        end else if (a[8] && off >= 16 && off < 144) begin
            if (busy[1-s][ch]) seen[1-s][ch][w] = 1'b1;
        end
    endtask

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one clock: drive at negedge, compare mid-low-phase, advance model at edge
    task automatic cyc(logic as, logic aw, logic [9:0] aa, logic [31:0] ad,
                       logic bs, logic bw, logic [9:0] ba, logic [31:0] bd);
        a_sel = as; a_wr = aw; a_addr = aa; a_wdata = ad;
        b_sel = bs; b_wr = bw; b_addr = ba; b_wdata = bd;
        #5;
        check("a_rdata", a_rdata, exp_rd(0, as, aw, aa));
        check("b_rdata", b_rdata, exp_rd(1, bs, bw, ba));
        check("a_irq R7", {31'd0, a_irq}, {31'd0, |(rxen[0] & busy[1])});
        check("b_irq R7", {31'd0, b_irq}, {31'd0, |(rxen[1] & busy[0])});
        apply(0, as, aw, aa, ad);
        apply(1, bs, bw, ba, bd);
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wa(logic [9:0] a, logic [31:0] d); cyc(1, 1, a, d, 0, 0, 0, 0); endtask
    task automatic ra(logic [9:0] a);                 cyc(1, 0, a, 0, 0, 0, 0, 0); endtask
    task automatic wb(logic [9:0] a, logic [31:0] d); cyc(0, 0, 0, 0, 1, 1, a, d); endtask
    task automatic rb(logic [9:0] a);                 cyc(0, 0, 0, 0, 1, 0, a, 0); endtask

    function automatic logic [9:0] txa(int n, int w); return 10'(16 + 32 * n + 4 * w); endfunction
    function automatic logic [9:0] rxa(int n, int w); return 10'(272 + 32 * n + 4 * w); endfunction

    initial begin
        for (int d = 0; d < 2; d++) begin
            busy[d] = 0; txen[d] = 0; rxen[d] = 0;
            for (int n = 0; n < 4; n++) begin
                seen[d][n] = 0;
                for (int w = 0; w < 8; w++) mem[d][n][w] = 0;
            end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        req = "R1";
        ra(10'h004); ra(10'h008); ra(10'h104); ra(10'h108);
        ra(txa(1, 3)); rb(rxa(2, 0)); rb(10'h008);

        req = "R2";
        wa(10'h004, 32'hFFFF_FFFF); ra(10'h004);
        wb(10'h104, 32'h5); rb(10'h104); wb(10'h104, 32'h0); rb(10'h104);

        req = "R3";
        for (int w = 0; w < 8; w++) wa(txa(2, w), 32'hA200_0000 + w);
        ra(txa(2, 5)); rb(rxa(2, 5)); rb(rxa(2, 7));

        req = "R4";
        wa(10'h000, 32'h4); ra(10'h008); rb(10'h108);

        req = "R7";
        wb(10'h104, 32'hF); rb(10'h108);

        req = "R5";
        wa(10'h000, 32'h4); ra(10'h008);
        wa(10'h004, 32'hE); wa(10'h000, 32'h1); ra(10'h008); rb(10'h108);
        wa(10'h004, 32'hF);

        req = "R6";
        wa(txa(2, 0), 32'hDEAD_BEEF); rb(rxa(2, 0)); ra(txa(2, 0));

        req = "R8";
        wb(10'h108, 32'h4); rb(10'h108);
        for (int w = 0; w < 7; w++) rb(rxa(2, w));
        rb(rxa(2, 3));
        wb(10'h108, 32'h4); ra(10'h008);
        rb(rxa(2, 7));
        wb(10'h108, 32'h0); wb(10'h108, 32'hB); rb(10'h108); ra(10'h008);

        req = "R9";
        wb(10'h108, 32'h4); ra(10'h008); rb(10'h108);
        wa(txa(2, 0), 32'h0000_1234); rb(rxa(2, 0));

        req = "R7";
        wa(10'h000, 32'h4); wb(10'h104, 32'hB); rb(10'h108);
        wb(10'h104, 32'hF); rb(10'h108);

        req = "R10";
        ra(10'h00C); ra(10'h000); ra(10'h0F0); ra(10'h3FC); ra(10'h1F0);
        ra(10'h100); ra(10'h006); ra(10'h00A);
        wa(10'h008, 32'hF); ra(10'h008);
        wa(10'h108, 32'h4); rb(10'h108);
        wa(10'h206, 32'h0); ra(10'h004);

        req = "R11";
        wb(10'h004, 32'hF);
        for (int w = 0; w < 8; w++) wb(txa(1, w), 32'hB100_0000 + w);
        for (int w = 0; w < 8; w++) wa(txa(3, w), 32'hA300_0000 + w);
        wa(10'h104, 32'hF);
        cyc(1, 1, 10'h000, 32'h8, 1, 1, 10'h000, 32'h2);
        ra(10'h108); rb(10'h108); ra(10'h008); rb(10'h008);
        for (int w = 7; w >= 0; w--) ra(rxa(1, w));
        wa(10'h108, 32'h2); rb(10'h008); ra(10'h108);
        for (int w = 0; w < 8; w++) rb(rxa(3, w));
        wb(10'h108, 32'h8); ra(10'h008); rb(10'h108);
        rb(rxa(2, 0));

        finish_up();
    end

endmodule